// File: doc/BRIEF.md
# Mode-Programmable Aligned Clock Divider

This block turns one fast clock into four related clocks, A through D, whose ratios are picked by a two-bit active-low mode input. A test-enable input swaps the fast clock for a separate test clock, through a glitch-free switch, and selects a second table of ratios. Every divided output comes from one shared phase counter with a common period of 48 selected-clock cycles. Because of that, rising edges line up and the whole pattern repeats on every counter wrap.

Three steerable output groups each drive a pair of pins. Each group copies B, C or D, or sits parked high. Mode and group selections are only taken up at the common-period boundary, so a change never cuts a pulse short. An active-low reset forces all outputs low and restarts the shared counter at zero.

Top module: `skew_clk_div`

## Requirements
- R1: While `rst_n_i` is low, `out_a_o`, `out_b_o`, `out_c_o`, `out_d_o` and every `grp_o` pin are 0. This holds in every mode, including divide-by-1.
- R2: The mode pins are active-low: the decoded mode is `~dsel_n_i`, so pins at 11 select normal mode 0. With `tst_en_i` low, mode 0 gives A, B, C, D at source /4, /4, /8, /16.
- R3: Normal mode 1 (decoded 01) gives A, B, C, D at /4, /6, /12, /24.
- R4: Normal mode 2 (decoded 10) gives A, B, C, D at /2, /4, /8, /16.
- R5: Normal mode 3 (decoded 11) holds A, B, C and D high.
- R6: With `tst_en_i` high, the test clock drives all outputs. Test modes 0, 1 and 3 give A, B, C, D at /2,/2,/4,/8; /2,/3,/6,/12; and /2,/2,/2,/2.
- R7: Test mode 2 gives B, C, D at /2, /4, /8, and A is the selected clock passed straight through.
- R8: For a division N ≥ 2, an output is high for the first ceil(N/2) cycles of each N-cycle period. This gives 2 high and 1 low for /3, and 50% duty for even N.
- R9: After reset release, the first rising edge of A, B, C and D comes on the first selected-clock rising edge. Edge k uses phase (k-1) mod 48.
- R10: Group g uses bits `gsel_i[2g+1:2g]`: 00 copies B, 01 copies C, 10 copies D, 11 parks both pins `grp_o[2g]` and `grp_o[2g+1]` high.
- R11: A change of mode or group select made mid-period takes effect only from the first edge of the next 48-cycle period. The edge after reset counts as a period start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk_i | input | 1 | Fast source clock |
| tst_clk_i | input | 1 | External test clock |
| tst_en_i | input | 1 | Selects test clock and test ratio table |
| rst_n_i | input | 1 | Active-low reset, outputs forced low |
| dsel_n_i | input | 2 | Active-low divider mode select |
| gsel_i | input | 2*NGRP | Two select bits per output group |
| out_a_o | output | 1 | Clock output A |
| out_b_o | output | 1 | Clock output B |
| out_c_o | output | 1 | Clock output C |
| out_d_o | output | 1 | Clock output D |
| grp_o | output | 2*NGRP | Group outputs, two pins per group |

## Verification
Divided outputs are registered, so the value for phase p appears on the selected clock's rising edge k = p+1 after release. The bench samples a quarter period after each edge, while the clock is still high. At that point the pass-through output of test mode 2 must also read 1. A select change made after edge 10 must not show until edge 49, the first edge of the next period, so the bench keeps the old expectation up to edge 48. Switching between the source and test clocks takes a few edges of each clock, so it is done only during reset with a settling wait.

// File: rtl/scd_pkg.sv
package scd_pkg;

    typedef struct packed {
        logic       tst;
        logic [1:0] mode;
    } cfg_t;

    typedef struct packed {
        logic [4:0] a;
        logic [4:0] b;
        logic [4:0] c;
        logic [4:0] d;
        logic       hold;
    } ratio_t;

    typedef enum logic [1:0] {
        G_B    = 2'b00,
        G_C    = 2'b01,
        G_D    = 2'b10,
        G_PARK = 2'b11
    } gsel_e;

    function automatic ratio_t ratio_of(cfg_t cf);
        ratio_t r;
        r = '{a: 5'd1, b: 5'd1, c: 5'd1, d: 5'd1, hold: 1'b0};
        case ({cf.tst, cf.mode})
            3'b000: r = '{a: 5'd4, b: 5'd4, c: 5'd8,  d: 5'd16, hold: 1'b0};
            3'b001: r = '{a: 5'd4, b: 5'd6, c: 5'd12, d: 5'd24, hold: 1'b0};
            3'b010: r = '{a: 5'd2, b: 5'd4, c: 5'd8,  d: 5'd16, hold: 1'b0};
            3'b011: r = '{a: 5'd1, b: 5'd1, c: 5'd1,  d: 5'd1,  hold: 1'b1};
            3'b100: r = '{a: 5'd2, b: 5'd2, c: 5'd4,  d: 5'd8,  hold: 1'b0};
            3'b101: r = '{a: 5'd2, b: 5'd3, c: 5'd6,  d: 5'd12, hold: 1'b0};
            3'b110: r = '{a: 5'd1, b: 5'd2, c: 5'd4,  d: 5'd8,  hold: 1'b0};
            default: r = '{a: 5'd2, b: 5'd2, c: 5'd2, d: 5'd2,  hold: 1'b0};
        endcase
        return r;
    endfunction

    function automatic logic phase_high(int p, int n);
        return (p % n) < ((n + 1) / 2);
    endfunction

endpackage

// File: rtl/scd_clk_mux.sv
module scd_clk_mux (
    input  logic src_clk_i,
    input  logic tst_clk_i,
    input  logic sel_tst_i,
    output logic clk_o,
    output logic en_src_o,
    output logic en_tst_o
);
    logic s1_d, s1_q, s2_q;
    logic t1_d, t1_q, t2_q;

    always_comb begin
        s1_d = ~sel_tst_i & ~t2_q;
        t1_d =  sel_tst_i & ~s2_q;
    end

    always_ff @(negedge src_clk_i) begin
        s1_q <= s1_d;
        s2_q <= s1_q;
    end

    always_ff @(negedge tst_clk_i) begin
        t1_q <= t1_d;
        t2_q <= t1_q;
    end

    assign clk_o    = (src_clk_i & s2_q) | (tst_clk_i & t2_q);
    assign en_src_o = s2_q;
    assign en_tst_o = t2_q;
endmodule

// File: rtl/scd_core.sv
module scd_core
    import scd_pkg::*;
#(
    parameter int PERIOD = 48,
    parameter int NGRP   = 3,
    localparam int CW    = $clog2(PERIOD),
    localparam int GW    = 2 * NGRP
) (
    input  logic            clk_i,
    input  logic            rst_n_i,
    input  cfg_t            cfg_i,
    input  logic [GW-1:0]   gsel_i,
    output logic            a_o,
    output logic            b_o,
    output logic            c_o,
    output logic            d_o,
    output logic [NGRP-1:0] grp_o,
    output logic            pass_next_o,
    output logic [CW-1:0]   cnt_o,
    output cfg_t            cfg_o,
    output logic [GW-1:0]   gsel_o
);
    typedef struct packed {
        logic [CW-1:0]   cnt;
        cfg_t            cfg;
        logic [GW-1:0]   gsel;
        logic            a;
        logic            b;
        logic            c;
        logic            d;
        logic [NGRP-1:0] grp;
    } st_t;

    st_t    st_d, st_q;
    cfg_t   eff_cfg;
    ratio_t rt;
    logic   at_wrap;
    logic   boundary;
    int     ph;

    always_comb begin
        boundary = (st_q.cnt == '0);
        at_wrap  = (st_q.cnt == CW'(PERIOD - 1));
        eff_cfg  = boundary ? cfg_i : st_q.cfg;
        rt       = ratio_of(eff_cfg);
        ph       = int'(st_q.cnt);

        st_d      = st_q;
        st_d.cfg  = eff_cfg;
        st_d.gsel = boundary ? gsel_i : st_q.gsel;
        st_d.cnt  = at_wrap ? '0 : st_q.cnt + CW'(1);
        st_d.a    = rt.hold | phase_high(ph, int'(rt.a));
        st_d.b    = rt.hold | phase_high(ph, int'(rt.b));
        st_d.c    = rt.hold | phase_high(ph, int'(rt.c));
        st_d.d    = rt.hold | phase_high(ph, int'(rt.d));
        for (int g = 0; g < NGRP; g++) begin
            case (gsel_e'(st_d.gsel[2*g +: 2]))
                G_B:     st_d.grp[g] = st_d.b;
                G_C:     st_d.grp[g] = st_d.c;
                G_D:     st_d.grp[g] = st_d.d;
                default: st_d.grp[g] = 1'b1;
            endcase
        end
        pass_next_o = eff_cfg.tst & (eff_cfg.mode == 2'b10);
    end

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) st_q <= '0;
        else          st_q <= st_d;
    end

    assign a_o    = st_q.a;
    assign b_o    = st_q.b;
    assign c_o    = st_q.c;
    assign d_o    = st_q.d;
    assign grp_o  = st_q.grp;
    assign cnt_o  = st_q.cnt;
    assign cfg_o  = st_q.cfg;
    assign gsel_o = st_q.gsel;
endmodule

// File: rtl/scd_bypass.sv
module scd_bypass (
    input  logic clk_i,
    input  logic rst_n_i,
    input  logic pass_next_i,
    input  logic a_reg_i,
    output logic a_o
);
    logic pass_d, pass_q;

    always_comb pass_d = pass_next_i;

    always_ff @(negedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) pass_q <= 1'b0;
        else          pass_q <= pass_d;
    end

    assign a_o = pass_q ? clk_i : a_reg_i;
endmodule

// File: rtl/skew_clk_div.sv
module skew_clk_div
    import scd_pkg::*;
#(
    parameter int PERIOD = 48,
    parameter int NGRP   = 3
) (
    input  logic              src_clk_i,
    input  logic              tst_clk_i,
    input  logic              tst_en_i,
    input  logic              rst_n_i,
    input  logic [1:0]        dsel_n_i,
    input  logic [2*NGRP-1:0] gsel_i,
    output logic              out_a_o,
    output logic              out_b_o,
    output logic              out_c_o,
    output logic              out_d_o,
    output logic [2*NGRP-1:0] grp_o
);
    localparam int CW = $clog2(PERIOD);
    localparam int GW = 2 * NGRP;

    logic            clk_m;
    logic            en_src, en_tst;
    logic            a_q, pass_next;
    logic [NGRP-1:0] grp_w;
    logic [CW-1:0]   cnt_w;
    cfg_t            cfg_w;
    cfg_t            cfg_in;
    logic [GW-1:0]   gsel_w;

    assign cfg_in = '{tst: tst_en_i, mode: ~dsel_n_i};

    scd_clk_mux i_mux (
        .src_clk_i (src_clk_i),
        .tst_clk_i (tst_clk_i),
        .sel_tst_i (tst_en_i),
        .clk_o     (clk_m),
        .en_src_o  (en_src),
        .en_tst_o  (en_tst)
    );

    scd_core #(.PERIOD(PERIOD), .NGRP(NGRP)) i_core (
        .clk_i       (clk_m),
        .rst_n_i     (rst_n_i),
        .cfg_i       (cfg_in),
        .gsel_i      (gsel_i),
        .a_o         (a_q),
        .b_o         (out_b_o),
        .c_o         (out_c_o),
        .d_o         (out_d_o),
        .grp_o       (grp_w),
        .pass_next_o (pass_next),
        .cnt_o       (cnt_w),
        .cfg_o       (cfg_w),
        .gsel_o      (gsel_w)
    );

    scd_bypass i_byp (
        .clk_i       (clk_m),
        .rst_n_i     (rst_n_i),
        .pass_next_i (pass_next),
        .a_reg_i     (a_q),
        .a_o         (out_a_o)
    );

    for (genvar g = 0; g < NGRP; g++) begin : g_pair
        assign grp_o[2*g]   = grp_w[g];
        assign grp_o[2*g+1] = grp_w[g];
    end
endmodule

// File: rtl/scd_chk.sv
module scd_chk #(
    parameter int NGRP = 3,
    parameter int CW   = 6
) (
    input logic              clk_m,
    input logic              src_clk,
    input logic              rst_n,
    input logic              a_q,
    input logic              b,
    input logic              c,
    input logic              d,
    input logic [2*NGRP-1:0] grp,
    input logic [CW-1:0]     cnt,
    input logic [2:0]        cfg,
    input logic [2*NGRP-1:0] gsel,
    input logic              en_src,
    input logic              en_tst
);
    // R1
    rst_low_chk: assert property (@(negedge src_clk)
        !rst_n |-> ({a_q, b, c, d, grp} == '0));

    // R5
    forced_high_chk: assert property (@(posedge clk_m) disable iff (!rst_n)
        (cnt != '0 && cfg == 3'b011) |-> (a_q & b & c & d));

    // R9
    aligned_rise_chk: assert property (@(posedge clk_m) disable iff (!rst_n)
        (cnt == CW'(1)) |-> (a_q & b & c & d));

    // R11
    cfg_hold_chk: assert property (@(posedge clk_m) disable iff (!rst_n)
        !$stable({cfg, gsel}) |-> (cnt == CW'(1)));

    // R6
    mux_excl_chk: assert property (@(posedge src_clk)
        $onehot0({en_src, en_tst}));

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        // R10
        park_high_chk: assert property (@(posedge clk_m) disable iff (!rst_n)
            (cnt != '0 && gsel[2*g +: 2] == 2'b11) |-> (grp[2*g] & grp[2*g+1]));
        // R10
        copy_b_chk: assert property (@(posedge clk_m) disable iff (!rst_n)
            (cnt != '0 && gsel[2*g +: 2] == 2'b00) |-> (grp[2*g] == b));
    end
endmodule

bind skew_clk_div scd_chk #(.NGRP(NGRP), .CW(CW)) i_chk (
    .clk_m   (clk_m),
    .src_clk (src_clk_i),
    .rst_n   (rst_n_i),
    .a_q     (a_q),
    .b       (out_b_o),
    .c       (out_c_o),
    .d       (out_d_o),
    .grp     (grp_o),
    .cnt     (cnt_w),
    .cfg     (cfg_w),
    .gsel    (gsel_w),
    .en_src  (en_src),
    .en_tst  (en_tst)
);

// File: tb/test_skew_clk_div.sv
module test_skew_clk_div;
    localparam int NG = 3;

    logic          src_clk = 1'b0;
    logic          tst_clk = 1'b0;
    logic          tst_en  = 1'b0;
    logic          rst_n   = 1'b0;
    logic [1:0]    dsel_n  = 2'b11;
    logic [2*NG-1:0] gsel  = '0;
    logic          oa, ob, oc, od;
    logic [2*NG-1:0] grp;

    int n_chk = 0;
    int n_bad = 0;

    always #10 src_clk = ~src_clk;
    always #16 tst_clk = ~tst_clk;

    skew_clk_div #(.PERIOD(48), .NGRP(NG)) i_skew_clk_div (
        .src_clk_i (src_clk),
        .tst_clk_i (tst_clk),
        .tst_en_i  (tst_en),
        .rst_n_i   (rst_n),
        .dsel_n_i  (dsel_n),
        .gsel_i    (gsel),
        .out_a_o   (oa),
        .out_b_o   (ob),
        .out_c_o   (oc),
        .out_d_o   (od),
        .grp_o     (grp)
    );

    task automatic chk(string tag, string nm, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, nm, act, exp, $time);
        end
    endtask

    task automatic tick();
        if (tst_en) begin @(posedge tst_clk); #8; end
        else        begin @(posedge src_clk); #5; end
    endtask

    function automatic int dv(bit t, bit [1:0] m, int ch);
        case ({t, m})
            3'b000: return (ch == 0) ? 4 : (ch == 1) ? 4 : (ch == 2) ? 8 : 16;
            3'b001: return (ch == 0) ? 4 : (ch == 1) ? 6 : (ch == 2) ? 12 : 24;
            3'b010: return (ch == 0) ? 2 : (ch == 1) ? 4 : (ch == 2) ? 8 : 16;
            3'b100: return (ch == 0) ? 2 : (ch == 1) ? 2 : (ch == 2) ? 4 : 8;
            3'b101: return (ch == 0) ? 2 : (ch == 1) ? 3 : (ch == 2) ? 6 : 12;
            3'b110: return (ch == 0) ? 1 : (ch == 1) ? 2 : (ch == 2) ? 4 : 8;
            3'b111: return 2;
            default: return 1;
        endcase
    endfunction

    function automatic string tag_of(bit t, bit [1:0] m, int ch);
        if (!t) begin
            case (m)
                2'd0: return "R2";
                2'd1: return "R3";
                2'd2: return "R4";
                default: return "R5";
            endcase
        end
        if (m == 2'd2) return "R7";
        if (m == 2'd1 && ch == 1) return "R8";
        return "R6";
    endfunction

    function automatic logic exp_out(bit t, bit [1:0] m, int ch, int p);
        int n;
        if (!t && m == 2'd3) return 1'b1;
        n = dv(t, m, ch);
        return (p % n) < ((n + 1) / 2);
    endfunction

    // Shared sequence: reset, release, compare every output on each edge.
    task automatic run(bit t, bit [1:0] m, bit [5:0] gs,
                       bit [1:0] m2, bit [5:0] gs2, int chg_after, int nt);
        logic [3:0] act;
        rst_n  = 1'b0;
        tst_en = t;
        dsel_n = ~m;
        gsel   = gs;
        #600;
        tick();
        chk("R1", "A-D in reset", |{oa, ob, oc, od}, 1'b0);
        chk("R1", "groups in reset", |grp, 1'b0);
        rst_n = 1'b1;
        for (int k = 1; k <= nt; k++) begin
            bit         nw;
            bit [1:0]   cm;
            bit [5:0]   cg;
            int         p;
            string      tg;
            if (chg_after != 0 && k == chg_after + 1) begin
                dsel_n = ~m2;
                gsel   = gs2;
            end
            tick();
            p  = (k - 1) % 48;
            nw = (chg_after != 0) && (k > 48);
            cm = nw ? m2 : m;
            cg = nw ? gs2 : gs;
            act = {od, oc, ob, oa};
            for (int ch = 0; ch < 4; ch++) begin
                tg = (chg_after != 0 && k > chg_after) ? "R11" :
                     (k == 1) ? "R9" : tag_of(t, cm, ch);
                chk(tg, $sformatf("out%0d edge%0d", ch, k), act[ch], exp_out(t, cm, ch, p));
            end
            for (int g = 0; g < NG; g++) begin
                logic ge;
                bit [1:0] s;
                s  = cg[2*g +: 2];
                ge = (s == 2'b11) ? 1'b1 : exp_out(t, cm, int'(s) + 1, p);
                tg = (chg_after != 0 && k > chg_after) ? "R11" : "R10";
                chk(tg, $sformatf("grp%0d edge%0d", 2*g,   k), grp[2*g],   ge);
                chk(tg, $sformatf("grp%0d edge%0d", 2*g+1, k), grp[2*g+1], ge);
            end
        end
    endtask

    task automatic t_norm_m0(); run(1'b0, 2'd0, 6'b11_10_00, 2'd0, 6'b0, 0, 96); endtask
    task automatic t_norm_m1(); run(1'b0, 2'd1, 6'b01_00_10, 2'd1, 6'b0, 0, 96); endtask
    task automatic t_norm_m2(); run(1'b0, 2'd2, 6'b10_01_00, 2'd2, 6'b0, 0, 96); endtask
    task automatic t_norm_m3(); run(1'b0, 2'd3, 6'b00_11_01, 2'd3, 6'b0, 0, 96); endtask
    task automatic t_test_m0(); run(1'b1, 2'd0, 6'b10_01_00, 2'd0, 6'b0, 0, 96); endtask
    task automatic t_test_m1(); run(1'b1, 2'd1, 6'b00_10_01, 2'd1, 6'b0, 0, 96); endtask
    task automatic t_test_m2(); run(1'b1, 2'd2, 6'b11_00_10, 2'd2, 6'b0, 0, 96); endtask
    task automatic t_test_m3(); run(1'b1, 2'd3, 6'b01_10_11, 2'd3, 6'b0, 0, 96); endtask
    task automatic t_change();  run(1'b0, 2'd0, 6'b00_00_00, 2'd1, 6'b11_01_10, 10, 120); endtask

    initial begin
        #1_000_000;
        n_bad++;
        $display("FAIL watchdog expired at %0t", $time);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_norm_m0();
        t_norm_m1();
        t_norm_m2();
        t_norm_m3();
        t_test_m0();
        t_test_m1();
        t_test_m2();
        t_test_m3();
        t_change();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule